// File: doc/BRIEF.md
# Page Write Cycle Controller for a Serial Byte Memory

This block is the write side of a byte-addressed nonvolatile memory that sits behind a two-wire serial slave. The protocol engine decodes the bus and gives this block three kinds of events: a header that carries the starting address, one strobe for each data byte it receives, and a Stop. The block collects the data bytes in a one-page staging buffer that keeps a valid flag for each byte. The address counter moves only inside the selected page, so a long burst wraps to offset 0 and overwrites bytes that were staged earlier.

When a Stop closes a transaction that staged at least one byte, the block samples the protect input. If protect is low, it starts a self-timed busy period whose length is the parameter `WR_CYCLES`, counted in system clocks. At the end of that period it writes every flagged byte of the staging buffer into the selected page in a single step. While busy, it tells the protocol engine to refuse the bus with a NACK and it ignores every event. If protect is high at the Stop, nothing is written and the block stays ready. The array contents can be read at any time through a combinational read port.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, every array byte reads 8'hFF, `busy_o`, `done_o` and `nack_o` are low, and `cur_addr_o` is 0.
- R2: A header, one data byte and a Stop with `wp_i` low raise `busy_o` on the clock after the Stop. It stays high for exactly `WR_CYCLES` clocks, and the byte can be read from its address once `busy_o` has fallen.
- R3: Several data bytes after one header are stored at consecutive offsets, starting at the header offset (address bits OFF_W-1..0). All of them go into the page given by the upper address bits.
- R4: The in-page offset advances by one for each data byte. After offset PAGE_BYTES-1 it returns to offset 0 of the same page, and a later byte for an offset replaces the byte staged earlier for that offset.
- R5: A commit changes only the offsets that received a byte in that transaction. Every other byte of the page and of the array keeps its value.
- R6: A Stop with no data byte staged since the last header never raises `busy_o`.
- R7: While `busy_o` is high, `nack_o` is high and header, data and Stop events have no effect: `cur_addr_o` and the array do not change, and nothing is staged.
- R8: With `wp_i` high at the Stop, no busy period occurs and the array is unchanged. `nack_o` stays low for the whole transaction, so every byte is still acknowledged.
- R9: A change of `wp_i` after the Stop does not shorten or cancel a busy period that has already started.
- R10: `done_o` is a single-clock pulse, high in the first clock after `busy_o` falls.
- R11: After a committed write, `cur_addr_o` holds the same page and the last written offset plus one, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_i | input | 1 | Header event: load `hdr_addr_i` and clear the staging buffer |
| hdr_addr_i | input | AW | Starting address, page in the upper bits and offset in the lower OFF_W bits |
| byte_i | input | 1 | Data byte event |
| byte_data_i | input | 8 | Data byte value |
| stop_i | input | 1 | Stop event |
| wp_i | input | 1 | Write protect level, sampled with the Stop |
| rd_addr_i | input | AW | Array read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |
| cur_addr_o | output | AW | Current address counter |
| busy_o | output | 1 | Self-timed write period in progress |
| done_o | output | 1 | One-clock pulse at the end of a write period |
| nack_o | output | 1 | Protocol engine must NACK the bus |

## Verification
The bench drives a burst that crosses the page end and a burst longer than one page. A design that carries into the page number, or that adds bytes instead of replacing them, leaves the wrong bytes in the page. It then rewrites one byte inside a page that was already filled and checks that the neighbouring bytes keep their values, which catches a commit that writes the whole buffer or that erases the page first. It sends a header with no data followed by a Stop, and a protected transaction, and checks that neither one starts a busy period. It also drives a full transaction into the busy window and toggles `wp_i` just after a Stop. A design that leaks inputs during busy, or that samples protect late, writes the wrong data or ends the cycle early.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef logic [7:0] byte_t;
    localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/pgwr_addr.sv
module pgwr_addr #(
    parameter int PAGE_BYTES = 256,
    parameter int OFF_W      = 8,
    parameter int PG_W       = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [PG_W+OFF_W-1:0] load_addr_i,
    input  logic                  step_i,
    input  logic                  hold_i,
    output logic [PG_W-1:0]       page_o,
    output logic [OFF_W-1:0]      off_o
);
    typedef struct packed {
        logic [PG_W-1:0]  pg;
        logic [OFF_W-1:0] off;
    } addr_t;

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    addr_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.pg  = load_addr_i[PG_W+OFF_W-1:OFF_W];
            d.off = load_addr_i[OFF_W-1:0];
        end else if (step_i) begin
            d.off = (q.off == LAST_OFF) ? '0 : q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign page_o = q.pg;
    assign off_o  = q.off;

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable({page_o, off_o}));

    // R4
    off_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && off_o == LAST_OFF) |=> (off_o == '0 && $stable(page_o)));
endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
    parameter int PAGE_BYTES = 256,
    parameter int OFF_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic [7:0]              data_i,
    input  logic                    clr_i,
    input  logic                    busy_i,
    input  logic                    commit_i,
    output logic [PAGE_BYTES-1:0]   vld_o,
    output logic [PAGE_BYTES*8-1:0] dat_o,
    output logic                    any_o
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0]   vld;
        logic [PAGE_BYTES*8-1:0] dat;
    } stage_t;

    stage_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.vld = '0;
        end else if (wr_i) begin
            d.vld[off_i]          = 1'b1;
            d.dat[off_i*8 +: 8]   = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld_o = q.vld;
    assign dat_o = q.dat;
    assign any_o = |q.vld;

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !commit_i) |=> $stable(vld_o) && $stable(dat_o));

    // R4
    stage_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> (vld_o[$past(off_i)] && dat_o[$past(off_i)*8 +: 8] == $past(data_i)));
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic commit_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy = 1'b1;
                d.cnt  = LOAD;
            end
        end else if (q.cnt == '0) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end else begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o   = q.busy;
    assign done_o   = q.done;
    assign commit_o = q.busy && (q.cnt == '0);

    // R9
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !commit_o) |=> busy_o);

    // R10
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PAGES      = 8,
    parameter int OFF_W      = 8,
    parameter int PG_W       = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic [PG_W-1:0]         page_i,
    input  logic [PAGE_BYTES-1:0]   vld_i,
    input  logic [PAGE_BYTES*8-1:0] dat_i,
    input  logic [PG_W+OFF_W-1:0]   rd_addr_i,
    output logic [7:0]              rd_data_o
);
    localparam int DEPTH = PAGES * PAGE_BYTES;

    logic [DEPTH*8-1:0] mem_q, mem_d;

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int k = 0; k < PAGE_BYTES; k++) begin
                if (vld_i[k]) begin
                    mem_d[(int'(page_i) * PAGE_BYTES + k) * 8 +: 8] = dat_i[k*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= {DEPTH{ERASED}};
        else        mem_q <= mem_d;
    end

    assign rd_data_o = mem_q[int'(rd_addr_i) * 8 +: 8];

    // R5
    array_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(mem_q));
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
    parameter int PAGE_BYTES = 256,
    parameter int PAGES      = 8,
    parameter int WR_CYCLES  = 500000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = $clog2(PAGES),
    localparam int AW        = OFF_W + PG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hdr_i,
    input  logic [AW-1:0] hdr_addr_i,
    input  logic          byte_i,
    input  logic [7:0]    byte_data_i,
    input  logic          stop_i,
    input  logic          wp_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o,
    output logic [AW-1:0] cur_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          nack_o
);
    logic                    busy, done, commit;
    logic                    hdr_ok, byte_ok, stop_ok, start, clr;
    logic                    any;
    logic [PG_W-1:0]         page;
    logic [OFF_W-1:0]        off;
    logic [PAGE_BYTES-1:0]   vld;
    logic [PAGE_BYTES*8-1:0] dat;

    always_comb begin
        hdr_ok  = hdr_i  && !busy;
        byte_ok = byte_i && !busy;
        stop_ok = stop_i && !busy;
        start   = stop_ok && any && !wp_i;
        clr     = hdr_ok || (stop_ok && !start) || commit;
    end

    pgwr_addr #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .PG_W(PG_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load_i(hdr_ok), .load_addr_i(hdr_addr_i),
        .step_i(byte_ok), .hold_i(busy),
        .page_o(page), .off_o(off)
    );

    pgwr_buf #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_i(byte_ok), .off_i(off), .data_i(byte_data_i),
        .clr_i(clr), .busy_i(busy), .commit_i(commit),
        .vld_o(vld), .dat_o(dat), .any_o(any)
    );

    pgwr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .start_i(start),
        .busy_o(busy), .done_o(done), .commit_o(commit)
    );

    pgwr_array #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .OFF_W(OFF_W), .PG_W(PG_W)) u_arr (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .page_i(page), .vld_i(vld), .dat_i(dat),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    assign cur_addr_o = {page, off};
    assign busy_o     = busy;
    assign done_o     = done;
    assign nack_o     = busy;

    // R8
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i && !wp_i));

    // R6
    start_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(any));
endmodule

// File: tb/test_pgwr_ctrl.sv
module test_pgwr_ctrl;
    localparam int PB = 256;
    localparam int NP = 8;
    localparam int WR = 20;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_i = 1'b0;
    logic [AW-1:0] hdr_addr_i = '0;
    logic          byte_i = 1'b0;
    logic [7:0]    byte_data_i = '0;
    logic          stop_i = 1'b0;
    logic          wp_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [7:0]    rd_data_o;
    logic [AW-1:0] cur_addr_o;
    logic          busy_o, done_o, nack_o;

    pgwr_ctrl #(.PAGE_BYTES(PB), .PAGES(NP), .WR_CYCLES(WR)) i_pgwr_ctrl (
        .clk(clk), .rst_n(rst_n), .hdr_i(hdr_i), .hdr_addr_i(hdr_addr_i),
        .byte_i(byte_i), .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .cur_addr_o(cur_addr_o),
        .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o)
    );

    always #5 clk = ~clk;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_mem [NP*PB];
    logic [7:0] m_dat [PB];
    bit         m_vld [PB];
    int         m_page, m_off;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_hdr(input int a);
        @(negedge clk); hdr_i = 1'b1; hdr_addr_i = AW'(a);
        @(negedge clk); hdr_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        @(negedge clk); byte_i = 1'b1; byte_data_i = v;
        @(negedge clk); byte_i = 1'b0;
    endtask

    task automatic send_stop(input bit wp);
        @(negedge clk); stop_i = 1'b1; wp_i = wp;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic open_write(input int pg, input int off);
        send_hdr(pg * PB + off);
        for (int k = 0; k < PB; k++) m_vld[k] = 1'b0;
        m_page = pg;
        m_off  = off;
    endtask

    task automatic put(input logic [7:0] v);
        send_byte(v);
        m_dat[m_off] = v;
        m_vld[m_off] = 1'b1;
        m_off = (m_off + 1) % PB;
    endtask

    task automatic model_commit();
        for (int k = 0; k < PB; k++)
            if (m_vld[k]) exp_mem[m_page * PB + k] = m_dat[k];
    endtask

    // counts negedges with busy high, starting at the current negedge
    task automatic wait_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic cmp_page(input int pg, input string req);
        int bad = 0, act = 0, exp = 0;
        for (int k = 0; k < PB; k++) begin
            rd_addr_i = AW'(pg * PB + k);
            #1;
            if (rd_data_o !== exp_mem[pg * PB + k]) begin
                if (bad == 0) begin act = int'(rd_data_o); exp = int'(exp_mem[pg * PB + k]); end
                bad++;
            end
        end
        chk(bad == 0, req, act, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(done_o == 1'b0 && nack_o == 1'b0, "R1 done/nack", {done_o, nack_o}, 0);
        chk(cur_addr_o == '0, "R1 addr", cur_addr_o, 0);
        for (int p = 0; p < NP; p++) cmp_page(p, "R1 erased");
    endtask

    task automatic t_byte();
        int n;
        open_write(1, 5);
        put(8'hA5);
        send_stop(1'b0);
        wait_busy(n);
        chk(n == WR, "R2 busy length", n, WR);
        chk(done_o == 1'b1, "R10 done high", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single", done_o, 0);
        model_commit();
        cmp_page(1, "R2 byte stored R5");
        chk(cur_addr_o == AW'(1 * PB + 6), "R11 addr after byte", cur_addr_o, PB + 6);
    endtask

    task automatic t_page();
        int n;
        open_write(2, 10);
        for (int i = 0; i < 6; i++) put(8'h30 + 8'(i));
        send_stop(1'b0);
        wait_busy(n);
        model_commit();
        cmp_page(2, "R3 page burst");
        open_write(2, 12);
        put(8'h5C);
        send_stop(1'b0);
        wait_busy(n);
        model_commit();
        cmp_page(2, "R5 partial rewrite");
        cmp_page(1, "R5 other page");
    endtask

    task automatic t_wrap();
        int n;
        open_write(3, PB - 2);
        for (int i = 0; i < 4; i++) put(8'hC0 + 8'(i));
        send_stop(1'b0);
        wait_busy(n);
        model_commit();
        cmp_page(3, "R4 wrap at page end");
        cmp_page(4, "R4 no carry into next page");
        chk(cur_addr_o == AW'(3 * PB + 2), "R11 addr after wrap", cur_addr_o, 3 * PB + 2);
        open_write(4, 0);
        for (int i = 0; i < PB + 1; i++) put(8'(i * 7 + 1));
        send_stop(1'b0);
        wait_busy(n);
        model_commit();
        cmp_page(4, "R4 overwrite after full wrap");
        chk(cur_addr_o == AW'(4 * PB + 1), "R11 addr after overflow", cur_addr_o, 4 * PB + 1);
    endtask

    task automatic t_no_data();
        int seen = 0;
        send_hdr(5 * PB + 3);
        send_stop(1'b0);
        for (int i = 0; i < 5; i++) begin
            if (busy_o) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R6 header only", seen, 0);
    endtask

    task automatic t_protect();
        int seen = 0;
        open_write(5, 0);
        for (int i = 0; i < 3; i++) begin
            put(8'h11 + 8'(i));
            if (nack_o) seen++;
        end
        wp_i = 1'b1;
        send_stop(1'b1);
        for (int i = 0; i < 5; i++) begin
            if (busy_o || nack_o) seen++;
            @(negedge clk);
        end
        wp_i = 1'b0;
        chk(seen == 0, "R8 no busy or nack", seen, 0);
        cmp_page(5, "R8 array unchanged");
    endtask

    task automatic t_wp_late();
        int n;
        open_write(6, 40);
        put(8'h77);
        put(8'h78);
        @(negedge clk); stop_i = 1'b1; wp_i = 1'b0;
        @(negedge clk); stop_i = 1'b0; wp_i = 1'b1;
        wait_busy(n);
        wp_i = 1'b0;
        chk(n == WR, "R9 busy length with late wp", n, WR);
        model_commit();
        cmp_page(6, "R9 data committed");
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [AW-1:0] a0;
        open_write(7, 100);
        put(8'hE1);
        send_stop(1'b0);
        chk(nack_o == 1'b1, "R7 nack while busy", nack_o, 1);
        a0 = cur_addr_o;
        send_hdr(0 * PB + 50);
        send_byte(8'h99);
        send_byte(8'h98);
        send_stop(1'b0);
        chk(cur_addr_o == a0, "R7 addr frozen", cur_addr_o, a0);
        wait_busy(n);
        model_commit();
        @(negedge clk);
        cmp_page(7, "R7 busy write only");
        cmp_page(0, "R7 ignored header page");
        send_stop(1'b0);
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy_o) n++;
            @(negedge clk);
        end
        chk(n == 0, "R7 nothing staged during busy", n, 0);
    endtask

    initial begin
        for (int i = 0; i < NP * PB; i++) exp_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte();
        t_page();
        t_wrap();
        t_no_data();
        t_protect();
        t_wp_late();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule